// File: doc/BRIEF.md
# Masked Vector Multiply-Add Operand and Writeback Control

This block sits on both sides of a lane-parallel fused multiply-add array of up to sixteen 32-bit lanes. It does not do the arithmetic. On the way in, it takes a destination vector and two source vectors. A two-bit form code tells it which vector feeds each lane's multiplicand, multiplier and addend. The third source can be replaced in every lane by its lowest element, a scalar broadcast.

On the way out, the per-lane results come back on an input bus in the same cycle. The block then decides lane by lane what the new destination value is, based on four things:
- a write mask, which can be disabled;
- a choice between keeping the old destination value and writing zero for lanes the mask leaves out;
- an active length of 4, 8 or 16 lanes;
- the rule that everything above the active length is cleared.

The chosen writeback vector is registered and appears one cycle after a valid input, with a valid strobe.

The operand outputs are combinational from the inputs, so the external arithmetic can close its loop within the same cycle.

Top module: `vfma_ctl`

## Requirements
- R1: With form code 0, each lane's multiplicand is the destination element, its multiplier is the third-source element and its addend is the second-source element.
- R2: With form code 1, each lane's multiplicand is the second-source element, its multiplier is the destination element and its addend is the third-source element.
- R3: With form code 2, and also with code 3, each lane's multiplicand is the second-source element, its multiplier is the third-source element and its addend is the destination element.
- R4: When bcast is 1, every lane uses bits 31:0 of src3 wherever its third-source element would be routed. When bcast is 0, lane j uses bits 32j+31:32j of src3.
- R5: len_sel gives the active lane count: 0 gives 4 lanes, 1 gives 8 lanes, and 2 or 3 give 16 lanes. Every writeback bit at or above 32 times the active lane count is zero.
- R6: With mask_en at 0, every active lane writes back its lane result, whatever the mask and zero_mode are.
- R7: With mask_en at 1, an active lane whose mask bit is 1 writes back its lane result.
- R8: With mask_en at 1 and zero_mode at 0, an active lane whose mask bit is 0 writes back its old destination element.
- R9: With mask_en at 1 and zero_mode at 1, an active lane whose mask bit is 0 writes back zero.
- R10: Mask bits at positions at or above the active lane count have no effect. Those lanes stay zero.
- R11: The following timing and reset rules hold:
  - wb_vld is 1 in exactly the cycle after one with valid_in at 1.
  - wb_data changes only after a valid input and holds its value otherwise.
  - After reset, both wb_vld and wb_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operands, controls and lane results are valid this cycle |
| form | input | 2 | Operand ordering: 0, 1, or 2/3 as in R1 to R3 |
| len_sel | input | 2 | Active length: 0 for 128 bits, 1 for 256 bits, 2 or 3 for 512 bits |
| bcast | input | 1 | Use src3 element 0 in every lane |
| mask_en | input | 1 | Apply the write mask |
| zero_mode | input | 1 | Unselected lanes become zero (1) or keep the destination (0) |
| mask | input | 16 | Per-lane write mask, bit j for lane j |
| dst | input | 512 | Destination vector, also the first source |
| src2 | input | 512 | Second source vector |
| src3 | input | 512 | Third source vector |
| lane_res | input | 512 | Per-lane results from the arithmetic array |
| mul_a | output | 512 | Per-lane multiplicand |
| mul_b | output | 512 | Per-lane multiplier |
| add_c | output | 512 | Per-lane addend |
| wb_vld | output | 1 | Writeback vector valid |
| wb_data | output | 512 | Registered writeback vector |

## Verification
The hardest case to reach from the ports is a lane that the mask leaves out in merge mode. There the only sign of correct behaviour is that the old destination element appears instead of the lane result. That can only be seen if the two differ in every lane. The stimulus therefore gives every lane of every vector a distinct value that encodes the vector's seed and the lane number, so a wrong lane, a wrong source or a lost broadcast shows as a mismatch.

The sweep covers every length with mask patterns that set bits above the active count. It does so under all four combinations of mask enable and zeroing, so stray writes into the cleared region are visible. After each writeback, the inputs are changed with valid low to expose any update that happens without a valid input.

// File: rtl/vfma_ctl_pkg.sv
package vfma_ctl_pkg;

    // Operand ordering codes: which vector is multiplicand, multiplier, addend
    typedef enum logic [1:0] {
        FORM_132     = 2'd0,   // dst * src3 + src2
        FORM_213     = 2'd1,   // src2 * dst + src3
        FORM_231     = 2'd2,   // src2 * src3 + dst
        FORM_231_ALT = 2'd3    // same ordering as FORM_231
    } fma_form_e;

    localparam int LEN_SEL_W = 2;

endpackage

// File: rtl/vfma_lane_enable.sv
module vfma_lane_enable #(
    parameter int LANES     = 16,
    parameter int MIN_LANES = 4,
    parameter int LSW       = 2
) (
    input  logic [LSW-1:0]   len_sel,
    input  logic             mask_en,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] act,
    output logic [LANES-1:0] upd
);

    localparam logic [LANES-1:0] ONE = LANES'(1);

    int n_act;

    // Active lane count doubles per len_sel step, saturating at LANES.
    always_comb begin
        n_act = MIN_LANES << len_sel;
        if (n_act > LANES) begin
            n_act = LANES;
        end
        for (int j = 0; j < LANES; j++) begin
            act[j] = (j < n_act);
            upd[j] = act[j] & (~mask_en | mask[j]);
        end
    end

    // Active lanes always form a contiguous run from lane 0 (R5)
    always_comb begin
        if (!$isunknown(act)) begin
            p_act_contig_r5: assert ((act & (act + ONE)) == '0)
                else $error("active lanes not contiguous");
            p_min_active_r5: assert (&act[MIN_LANES-1:0])
                else $error("minimum lane group not active");
        end
    end

endmodule

// File: rtl/vfma_route.sv
module vfma_route
    import vfma_ctl_pkg::*;
#(
    parameter int LANES = 16,
    parameter int EW    = 32,
    localparam int VW   = LANES * EW
) (
    input  logic [1:0]    form,
    input  logic          bcast,
    input  logic [VW-1:0] dst,
    input  logic [VW-1:0] src2,
    input  logic [VW-1:0] src3,
    output logic [VW-1:0] mul_a,
    output logic [VW-1:0] mul_b,
    output logic [VW-1:0] add_c
);

    fma_form_e form_e;
    assign form_e = fma_form_e'(form);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [EW-1:0] s3_j;
        logic [EW-1:0] d_j;
        logic [EW-1:0] s2_j;

        assign d_j  = dst[j*EW +: EW];
        assign s2_j = src2[j*EW +: EW];
        assign s3_j = bcast ? src3[EW-1:0] : src3[j*EW +: EW];

        always_comb begin
            unique case (form_e)
                FORM_132: begin
                    mul_a[j*EW +: EW] = d_j;
                    mul_b[j*EW +: EW] = s3_j;
                    add_c[j*EW +: EW] = s2_j;
                end
                FORM_213: begin
                    mul_a[j*EW +: EW] = s2_j;
                    mul_b[j*EW +: EW] = d_j;
                    add_c[j*EW +: EW] = s3_j;
                end
                default: begin
                    mul_a[j*EW +: EW] = s2_j;
                    mul_b[j*EW +: EW] = s3_j;
                    add_c[j*EW +: EW] = d_j;
                end
            endcase
        end
    end

endmodule

// File: rtl/vfma_wb.sv
module vfma_wb #(
    parameter int LANES = 16,
    parameter int EW    = 32,
    localparam int VW   = LANES * EW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic             zero_mode,
    input  logic [LANES-1:0] act,
    input  logic [LANES-1:0] upd,
    input  logic [VW-1:0]    dst,
    input  logic [VW-1:0]    res,
    output logic             wb_vld,
    output logic [VW-1:0]    wb_data
);

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] data;
    } wb_st_t;

    wb_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_in;
        if (valid_in) begin
            for (int j = 0; j < LANES; j++) begin
                if (!act[j]) begin
                    st_d.data[j*EW +: EW] = '0;
                end else if (upd[j]) begin
                    st_d.data[j*EW +: EW] = res[j*EW +: EW];
                end else if (zero_mode) begin
                    st_d.data[j*EW +: EW] = '0;
                end else begin
                    st_d.data[j*EW +: EW] = dst[j*EW +: EW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wb_vld  = st_q.vld;
    assign wb_data = st_q.data;

    // Output holds when no valid input arrives (R11)
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(wb_data))
        else $error("writeback changed without valid input");

    for (genvar j = 0; j < LANES; j++) begin : g_chk
        // Lanes beyond the active length come out zero (R5, R10)
        p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            valid_in && !act[j] |=> wb_data[j*EW +: EW] == '0)
            else $error("inactive lane %0d not cleared", j);
        // Selected lane takes its result (R7)
        p_take_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
            valid_in && upd[j] |=> wb_data[j*EW +: EW] == $past(res[j*EW +: EW]))
            else $error("lane %0d lost its result", j);
        // Unselected lane in merge mode keeps destination (R8)
        p_merge_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            valid_in && act[j] && !upd[j] && !zero_mode
            |=> wb_data[j*EW +: EW] == $past(dst[j*EW +: EW]))
            else $error("lane %0d did not merge", j);
        // Unselected lane in zeroing mode becomes zero (R9)
        p_zero_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
            valid_in && act[j] && !upd[j] && zero_mode
            |=> wb_data[j*EW +: EW] == '0)
            else $error("lane %0d not zeroed", j);
    end

endmodule

// File: rtl/vfma_ctl.sv
module vfma_ctl
    import vfma_ctl_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int EW        = 32,
    parameter int MIN_LANES = 4,
    localparam int VW       = LANES * EW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [1:0]       form,
    input  logic [1:0]       len_sel,
    input  logic             bcast,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic [LANES-1:0] mask,
    input  logic [VW-1:0]    dst,
    input  logic [VW-1:0]    src2,
    input  logic [VW-1:0]    src3,
    input  logic [VW-1:0]    lane_res,
    output logic [VW-1:0]    mul_a,
    output logic [VW-1:0]    mul_b,
    output logic [VW-1:0]    add_c,
    output logic             wb_vld,
    output logic [VW-1:0]    wb_data
);

    logic [LANES-1:0] act;
    logic [LANES-1:0] upd;

    vfma_route #(.LANES(LANES), .EW(EW)) u_route (
        .form  (form),
        .bcast (bcast),
        .dst   (dst),
        .src2  (src2),
        .src3  (src3),
        .mul_a (mul_a),
        .mul_b (mul_b),
        .add_c (add_c)
    );

    vfma_lane_enable #(.LANES(LANES), .MIN_LANES(MIN_LANES), .LSW(LEN_SEL_W)) u_en (
        .len_sel (len_sel),
        .mask_en (mask_en),
        .mask    (mask),
        .act     (act),
        .upd     (upd)
    );

    vfma_wb #(.LANES(LANES), .EW(EW)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .zero_mode (zero_mode),
        .act       (act),
        .upd       (upd),
        .dst       (dst),
        .res       (lane_res),
        .wb_vld    (wb_vld),
        .wb_data   (wb_data)
    );

    // Strobe follows a valid input by exactly one cycle (R11)
    p_vld_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> wb_vld)
        else $error("missing writeback strobe");
    p_vld_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !wb_vld)
        else $error("spurious writeback strobe");

    // Routing per form code (R1, R2, R3)
    p_route_132_r1: assert property (@(posedge clk) disable iff (!rst_n)
        form == FORM_132 && !bcast |-> mul_a == dst && mul_b == src3 && add_c == src2)
        else $error("form 132 routing wrong");
    p_route_213_r2: assert property (@(posedge clk) disable iff (!rst_n)
        form == FORM_213 && !bcast |-> mul_a == src2 && mul_b == dst && add_c == src3)
        else $error("form 213 routing wrong");
    p_route_231_r3: assert property (@(posedge clk) disable iff (!rst_n)
        form[1] && !bcast |-> mul_a == src2 && mul_b == src3 && add_c == dst)
        else $error("form 231 routing wrong");

    // Broadcast makes every lane's third-source operand equal to lane 0's (R4)
    for (genvar j = 1; j < LANES; j++) begin : g_bc
        p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
            bcast && form == FORM_132 |-> mul_b[j*EW +: EW] == mul_b[EW-1:0])
            else $error("broadcast lane %0d differs", j);
    end

endmodule

// File: tb/sim_vfma_ctl.sv
module sim_vfma_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 16;
    localparam int EW         = 32;
    localparam int VW         = LANES * EW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid_in = 1'b0;
    logic [1:0]       form = '0;
    logic [1:0]       len_sel = '0;
    logic             bcast = 1'b0;
    logic             mask_en = 1'b0;
    logic             zero_mode = 1'b0;
    logic [LANES-1:0] mask = '0;
    logic [VW-1:0]    dst = '0, src2 = '0, src3 = '0, lane_res = '0;
    logic [VW-1:0]    mul_a, mul_b, add_c, wb_data;
    logic             wb_vld;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfma_ctl u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .form(form),
        .len_sel(len_sel), .bcast(bcast), .mask_en(mask_en),
        .zero_mode(zero_mode), .mask(mask), .dst(dst), .src2(src2),
        .src3(src3), .lane_res(lane_res), .mul_a(mul_a), .mul_b(mul_b),
        .add_c(add_c), .wb_vld(wb_vld), .wb_data(wb_data)
    );

    // Every lane of every vector distinct: seed, lane index, mixed low half
    function automatic logic [VW-1:0] pattern(input int seed);
        logic [VW-1:0] v;
        for (int j = 0; j < LANES; j++) begin
            v[j*EW +: EW] = {8'(seed), 8'(j), 16'(seed * 7 + j * 13) ^ 16'hA5C3};
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_wb(input int l, input int me, input int z, input logic [LANES-1:0] m, input int seed);
        logic [VW-1:0] exp;
        logic [VW-1:0] d0, r0;
        int n;
        string tag;
        n = (l == 0) ? 4 : (l == 1) ? 8 : 16;
        d0 = pattern(seed);
        r0 = pattern(seed + 1000);
        for (int j = 0; j < LANES; j++) begin
            if (j >= n)                       exp[j*EW +: EW] = '0;
            else if (me == 0 || m[j])         exp[j*EW +: EW] = r0[j*EW +: EW];
            else if (z != 0)                  exp[j*EW +: EW] = '0;
            else                              exp[j*EW +: EW] = d0[j*EW +: EW];
        end
        if (me == 0)   tag = "R6/R5";
        else if (z)    tag = "R7/R9/R5";
        else           tag = "R7/R8/R5";
        if (me != 0 && n < LANES && (m >> n) != '0) tag = {tag, "/R10"};
        @(negedge clk);
        valid_in  = 1'b1;
        len_sel   = 2'(l);
        mask_en   = 1'(me);
        zero_mode = 1'(z);
        mask      = m;
        dst       = d0;
        lane_res  = r0;
        src2      = pattern(seed + 2000);
        src3      = pattern(seed + 3000);
        @(negedge clk);
        chk(tag, wb_data, exp);
        chk("R11 strobe", {{(VW-1){1'b0}}, wb_vld}, {{(VW-1){1'b0}}, 1'b1});
        // Change everything with valid low; output must hold
        valid_in  = 1'b0;
        dst       = pattern(seed + 4000);
        lane_res  = pattern(seed + 5000);
        zero_mode = ~zero_mode;
        mask      = ~mask;
        @(negedge clk);
        chk("R11 hold", wb_data, exp);
        chk("R11 quiet", {{(VW-1){1'b0}}, wb_vld}, '0);
    endtask

    initial begin
        logic [VW-1:0] e_a, e_b, e_c, s3;
        logic [LANES-1:0] masks [4];
        string tag;
        masks[0] = 16'h0000;
        masks[1] = 16'hFFFF;
        masks[2] = 16'hA5A5;
        masks[3] = 16'h5A3C;

        repeat (3) @(negedge clk);
        // Reset state (R11)
        chk("R11 reset data", wb_data, '0);
        chk("R11 reset strobe", {{(VW-1){1'b0}}, wb_vld}, '0);
        rst_n = 1'b1;

        // Operand routing sweep: all form codes with and without broadcast
        for (int f = 0; f < 4; f++) begin
            for (int b = 0; b < 2; b++) begin
                @(negedge clk);
                form  = 2'(f);
                bcast = 1'(b);
                dst   = pattern(10 + f * 2 + b);
                src2  = pattern(40 + f * 2 + b);
                src3  = pattern(70 + f * 2 + b);
                #1;
                for (int j = 0; j < LANES; j++) begin
                    s3[j*EW +: EW] = b ? src3[EW-1:0] : src3[j*EW +: EW];
                end
                if (f == 0) begin
                    e_a = dst;  e_b = s3;  e_c = src2;  tag = "R1";
                end else if (f == 1) begin
                    e_a = src2; e_b = dst; e_c = s3;    tag = "R2";
                end else begin
                    e_a = src2; e_b = s3;  e_c = dst;   tag = "R3";
                end
                if (b) tag = {tag, "/R4"};
                chk({tag, " mul_a"}, mul_a, e_a);
                chk({tag, " mul_b"}, mul_b, e_b);
                chk({tag, " add_c"}, add_c, e_c);
            end
        end
        bcast = 1'b0;
        form  = 2'd0;

        // Writeback sweep: every length, mask mode, fill mode and mask pattern
        for (int l = 0; l < 4; l++) begin
            for (int me = 0; me < 2; me++) begin
                for (int z = 0; z < 2; z++) begin
                    for (int mi = 0; mi < 4; mi++) begin
                        run_wb(l, me, z, masks[mi], 100 + l * 16 + me * 8 + z * 4 + mi);
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule